// File: doc/BRIEF.md
# PWM Output Conditioning Stage

This block sits between a bank of PWM generators and the pins. Each raw PWM
signal goes through three gates: an enable mask that selects which outputs may
drive at all, a fault gate that forces an output to its inactive level while an
external fault is present and that output's fault-enable bit is set, and a
final per-output polarity inversion. Because the enable mask is one register,
a motor controller can commutate by rewriting a single word, without touching
the generators that the feedback loop is adjusting.

The fault input is asynchronous. It is synchronized through a chain of flops,
and the synchronized level both drives the fault gate and, when interrupt
reporting is enabled, sets a sticky fault status flag on its rising edge. The
flag stays set until it is cleared by a write. A disabled or faulted output is
always driven to its inactive level: logic 0 before inversion, so an inverted
output rests at logic 1.

Top module: `pwm_out_cond`

## Requirements
- R1: After reset the enable, fault-enable and invert masks, the interrupt enable and the fault status are all zero, so every output is 0 and `fault_irq` and `fault_active` are 0.
- R2: Each output bit equals (raw AND enable AND NOT(fault-enable AND `fault_active`)) XOR invert, per bit; the inactive level before inversion is 0.
- R3: A write with `wr_addr` = 0 loads the enable mask from `wr_data`; the new mask shows at every output together, right after the clock edge that captures the write and not before.
- R4: A write with `wr_addr` = 1 loads the fault-enable mask and a write with `wr_addr` = 2 loads the invert mask.
- R5: `fault_active` follows `fault_in` delayed by exactly two rising clock edges, for both the rise and the fall.
- R6: When the interrupt enable (bit 0 of a write to `wr_addr` = 3) is 1, the rising edge of `fault_active` sets `fault_irq` on the same clock edge; `fault_irq` then stays 1 after the fault goes away.
- R7: A write to `wr_addr` = 3 with bit 1 set clears `fault_irq`; a write to that address with bit 1 clear leaves it unchanged. Such a write also loads the interrupt enable from bit 0.
- R8: With the interrupt enable at 0, a rising `fault_active` leaves `fault_irq` at 0.
- R9: While `wr_en` is 0, the values on `wr_addr` and `wr_data` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 enable, 1 fault-enable, 2 invert, 3 control |
| wr_data | input | N_OUT | Write data; control uses bit 0 (interrupt enable) and bit 1 (clear status) |
| raw_pwm | input | N_OUT | Raw PWM signals from the generators |
| fault_in | input | 1 | Asynchronous fault input, active high |
| pwm_out | output | N_OUT | Conditioned PWM signals to the pins |
| fault_active | output | 1 | Synchronized fault level |
| fault_irq | output | 1 | Sticky fault status flag |

## Verification
The hardest situation to reach is the full interaction of the fault gate with
the masks: the forced level only shows for outputs whose fault-enable bit is
set while the synchronized fault is up, and inversion then flips the result.
The bench holds the fault steady long enough to pass the synchronizer, then
walks every combination of enable, fault-enable and invert mask on a four-output
instance and every raw pattern under each, once with the fault low and once
high. The two-edge synchronizer latency and the sticky flag are reached by
raising the fault at a known falling edge and sampling after each rising edge.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_FLTEN  = 2'd1,
        SEL_INVERT = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    localparam int CTRL_IRQEN_BIT = 0;
    localparam int CTRL_CLEAR_BIT = 1;

    typedef struct packed {
        logic raw;
        logic enable;
        logic flt_en;
        logic invert;
    } lane_cfg_t;

    function automatic logic lane_level(input lane_cfg_t c, input logic flt);
        logic driven;
        driven = c.raw & c.enable & ~(c.flt_en & flt);
        return driven ^ c.invert;
    endfunction

endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs
    import pwmc_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [N_OUT-1:0] wr_data,
    output logic [N_OUT-1:0] en_q,
    output logic [N_OUT-1:0] fen_q,
    output logic [N_OUT-1:0] inv_q,
    output logic             irq_en_q,
    output logic             clr_pulse
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            fen_q    <= '0;
            inv_q    <= '0;
            irq_en_q <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_ENABLE: en_q     <= wr_data;
                SEL_FLTEN:  fen_q    <= wr_data;
                SEL_INVERT: inv_q    <= wr_data;
                SEL_CTRL:   irq_en_q <= wr_data[CTRL_IRQEN_BIT];
                default:    ;
            endcase
        end
    end

    assign clr_pulse = wr_en && (sel == SEL_CTRL) && wr_data[CTRL_CLEAR_BIT];
endmodule

// File: rtl/pwmc_fault_sync.sv
module pwmc_fault_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_in,
    output logic fault_sync,
    output logic fault_rise
);
    localparam int LAST = STAGES - 1;
    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= fault_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign fault_sync = chain[LAST];
    assign fault_rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/pwmc_gate.sv
module pwmc_gate
    import pwmc_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic [N_OUT-1:0] raw,
    input  logic [N_OUT-1:0] en,
    input  logic [N_OUT-1:0] fen,
    input  logic [N_OUT-1:0] inv,
    input  logic             flt,
    output logic [N_OUT-1:0] pins
);
    genvar i;
    generate
        for (i = 0; i < N_OUT; i++) begin : g_lane
            lane_cfg_t cfg;
            assign cfg = '{raw: raw[i], enable: en[i], flt_en: fen[i], invert: inv[i]};
            assign pins[i] = lane_level(cfg, flt);
        end
    endgenerate
endmodule

// File: rtl/pwm_out_cond.sv
module pwm_out_cond
    import pwmc_pkg::*;
#(
    parameter int N_OUT       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [N_OUT-1:0] wr_data,
    input  logic [N_OUT-1:0] raw_pwm,
    input  logic             fault_in,
    output logic [N_OUT-1:0] pwm_out,
    output logic             fault_active,
    output logic             fault_irq
);
    logic [N_OUT-1:0] en_q, fen_q, inv_q;
    logic             irq_en_q, clr_pulse, fault_rise;

    pwmc_regs #(.N_OUT(N_OUT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .en_q(en_q), .fen_q(fen_q), .inv_q(inv_q), .irq_en_q(irq_en_q),
        .clr_pulse(clr_pulse)
    );

    pwmc_fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .fault_in(fault_in),
        .fault_sync(fault_active), .fault_rise(fault_rise)
    );

    pwmc_gate #(.N_OUT(N_OUT)) u_gate (
        .raw(raw_pwm), .en(en_q), .fen(fen_q), .inv(inv_q),
        .flt(fault_active), .pins(pwm_out)
    );

    // A new fault edge beats a clear arriving in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)                         fault_irq <= 1'b0;
        else if (fault_rise && irq_en_q) fault_irq <= 1'b1;
        else if (clr_pulse)              fault_irq <= 1'b0;
    end
endmodule

// File: rtl/pwmc_checker.sv
module pwmc_checker #(
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [N_OUT-1:0] wr_data,
    input logic             fault_in,
    input logic [N_OUT-1:0] pwm_out,
    input logic             fault_active,
    input logic             fault_irq,
    input logic [N_OUT-1:0] en_q,
    input logic [N_OUT-1:0] inv_q,
    input logic             irq_en_q
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)           age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    assert_sync_delay_R5: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (fault_active == $past(fault_in, 2)));

    assert_enable_load_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0) |=> (en_q == $past(wr_data)));

    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (((pwm_out ^ inv_q) & ~en_q) == '0));

    assert_irq_set_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(fault_active) && $past(irq_en_q)) |-> fault_irq);

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (fault_irq && !(wr_en && wr_addr == 2'd3 && wr_data[1])) |=> fault_irq);

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_irq) |-> ($rose(fault_active) && $past(irq_en_q)));
endmodule

bind pwm_out_cond pwmc_checker #(.N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fault_in(fault_in), .pwm_out(pwm_out), .fault_active(fault_active),
    .fault_irq(fault_irq), .en_q(en_q), .inv_q(inv_q), .irq_en_q(irq_en_q)
);

// File: tb/tb_pwm_out_cond.sv
module tb_pwm_out_cond;
    localparam int N = 4;
    localparam time CLK_PERIOD = 10;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] raw_pwm = '0;
    logic         fault_in = 1'b0;
    logic [N-1:0] pwm_out;
    logic         fault_active, fault_irq;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    pwm_out_cond #(.N_OUT(N), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .raw_pwm(raw_pwm), .fault_in(fault_in), .pwm_out(pwm_out),
        .fault_active(fault_active), .fault_irq(fault_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [1:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    function automatic logic [N-1:0] model(input logic [N-1:0] r, e, f, v, input logic flt);
        return (r & e & ~(flt ? f : '0)) ^ v;
    endfunction

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        raw_pwm = '1; #1;
        check("R1 pwm_out", pwm_out, 0);
        check("R1 fault_irq", fault_irq, 0);
        check("R1 fault_active", fault_active, 0);
        @(negedge clk);

        // R9 write strobe low: nothing loads
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = '1; tick();
        wr_addr = 2'd2; tick();
        check("R9 no write", pwm_out, 0);

        // R3 all outputs switch together, only after the edge
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 4'b1011; #1;
        check("R3 before edge", pwm_out, 0);
        @(posedge clk); #1;
        check("R3 after edge", pwm_out, 4'b1011);
        @(negedge clk); wr_en = 1'b0;
        write(2'd0, 4'b0110);
        check("R3 commutate", pwm_out, 4'b0110);

        // R2 R4 exhaustive mask and raw sweep, fault low then high
        for (int fl = 0; fl < 2; fl++) begin
            fault_in = fl[0]; tick(); tick(); tick();
            check("R5 settled", fault_active, fl);
            for (int e = 0; e < 16; e++)
                for (int f = 0; f < 16; f++)
                    for (int v = 0; v < 16; v++) begin
                        write(2'd0, e[N-1:0]);
                        write(2'd1, f[N-1:0]);
                        write(2'd2, v[N-1:0]);
                        for (int r = 0; r < 16; r++) begin
                            raw_pwm = r[N-1:0]; #1;
                            check("R2 R4 gating", pwm_out,
                                  model(r[N-1:0], e[N-1:0], f[N-1:0], v[N-1:0], fl[0]));
                        end
                    end
        end
        fault_in = 1'b0; tick(); tick(); tick();

        // R6 R5 timing with interrupt enabled
        write(2'd0, 4'b1111); write(2'd1, 4'b0101); write(2'd2, 4'b0000);
        raw_pwm = 4'b1111;
        write(2'd3, 4'b0011); // enable and clear
        check("R7 cleared", fault_irq, 0);
        fault_in = 1'b1; tick();
        check("R5 one edge", fault_active, 0);
        check("R2 not yet forced", pwm_out, 4'b1111);
        tick();
        check("R5 two edges", fault_active, 1);
        check("R6 set", fault_irq, 1);
        check("R2 forced", pwm_out, 4'b1010);
        fault_in = 1'b0; tick();
        check("R5 fall one edge", fault_active, 1);
        tick();
        check("R5 fall two edges", fault_active, 0);
        check("R6 sticky", fault_irq, 1);

        // R7 clear semantics
        write(2'd3, 4'b0001);
        check("R7 no clear bit", fault_irq, 1);
        write(2'd3, 4'b0010); // clear and disable interrupts
        check("R7 clear", fault_irq, 0);

        // R8 disabled interrupt
        fault_in = 1'b1; tick(); tick(); tick();
        check("R8 fault seen", fault_active, 1);
        check("R8 no status", fault_irq, 0);
        fault_in = 1'b0; tick(); tick(); tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule